// File: doc/BRIEF.md
# Transmit Work-Queue Consumer

This block drains a ring of single-word work entries that a host fills. Each word hands over a whole chain of buffer descriptors for one connection. The word holds an ownership flag, a pointer to the first descriptor of the chain, and the index of the connection the chain belongs to. The host writes words into the shared ring storage through a plain write port. The consumer keeps a head pointer into the ring and reads the word at that slot. When the flag is set, it raises a link request to the downstream segmentation logic. The request carries the chain pointer and the connection index.

Once the downstream logic acknowledges the link, the consumer clears the ownership flag of that slot in the ring storage. It then steps its head pointer to the next slot. It never compares a head against a tail. When the slot at the head is not owned by it, the consumer reads the same slot again on every cycle it can and waits there. The ring storage has a single port. The host always wins that port, so a consumer read or clear that meets a host write waits and is retried on a later cycle.

Top module: `txq_consumer`

## Requirements
- R1: An entry word has the ownership flag at bit 0, the connection index at bits [IDX_W:1] and the chain pointer at bits [ENT_W-1:IDX_W+1]. A host write of `host_wr_data` lands in slot `host_wr_addr`.
- R2: After reset, `link_req` is 0, `head` is 0, and every slot reads as not owned.
- R3: When the slot at `head` holds a word with bit 0 set, `link_req` rises, with `link_ptr` and `link_idx` equal to that word's pointer and index fields.
- R4: When the slot at `head` has bit 0 clear, no request is raised and `head` holds. The slot keeps being re-read, so a later host write that sets bit 0 is picked up.
- R5: While `link_req` is high and `link_ack` is low, `link_req`, `link_ptr` and `link_idx` stay unchanged.
- R6: A cycle with `link_req` and `link_ack` both high is followed by `link_req` low. Once the clear of bit 0 in that slot has been carried out, `head` then steps by one.
- R7: Owned slots are linked in ring order, and `head` wraps from DEPTH-1 to 0.
- R8: In any cycle with `host_wr_en` high, the consumer gets no access to the storage. `head` therefore does not change at the edge that ends such a cycle, and a consumer read or clear is retried after the host stops writing.
- R9: A slot that has been consumed is not linked again when the head wraps back to it. It is linked again only after the host writes a new word with bit 0 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe into the ring storage |
| host_wr_addr | input | AW | Slot written by the host |
| host_wr_data | input | ENT_W | Entry word written by the host |
| link_req | output | 1 | Link request to downstream |
| link_ptr | output | PTR_W | Descriptor chain pointer of the request |
| link_idx | output | IDX_W | Connection index of the request |
| link_ack | input | 1 | Downstream acknowledge of the link |
| head | output | AW | Current consumer slot |

## Verification
Two things compete for the same cycle: a host write, and a consumer poll read or flag clear. Both need the single storage port. The bench provokes this by holding the host write strobe high across the cycles in which a valid entry would otherwise be read. It does the same across the cycle right after an acknowledge, when the flag clear is due. It then expects no request, or an unmoved head, for as long as the host writes. It also expects the request or the head step to appear promptly once the strobe drops.

// File: rtl/txq_pkg.sv
// Shared types for the transmit work-queue consumer.
package txq_pkg;
    // Consumer sequencing states
    typedef enum logic [1:0] {
        ST_POLL  = 2'd0,   // reading the head slot until it is owned
        ST_LINK  = 2'd1,   // request raised, waiting for acknowledge
        ST_CLEAR = 2'd2    // writing the ownership flag back to zero
    } cons_state_t;
endpackage

// File: rtl/txq_ring_mem.sv
// Single-ported ring storage for work entries.
// The host write always wins the port. A consumer access is granted only in
// a cycle with no host write. A granted read returns its word one cycle later,
// flagged by c_rvalid. A granted clear zeroes bit 0 of the addressed slot.
// Assumes DEPTH is a power of two; all slots reset to zero (not owned).
module txq_ring_mem #(
    parameter int DEPTH = 16,
    parameter int ENT_W = 35,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             h_we,
    input  logic [AW-1:0]    h_addr,
    input  logic [ENT_W-1:0] h_data,
    input  logic             c_req,
    input  logic             c_clr,
    input  logic [AW-1:0]    c_addr,
    output logic             c_grant,
    output logic [ENT_W-1:0] c_rdata,
    output logic             c_rvalid
);
    logic [ENT_W-1:0] slots [DEPTH];

    // Port arbitration: host has priority
    always_comb c_grant = c_req && !h_we;

    // One register per slot; host write or consumer flag clear
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else if (h_we && h_addr == AW'(g)) begin
                slots[g] <= h_data;
            end else if (c_grant && c_clr && c_addr == AW'(g)) begin
                slots[g][0] <= 1'b0;
            end
        end
    end

    // Registered read for the consumer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_rdata  <= '0;
            c_rvalid <= 1'b0;
        end else begin
            c_rvalid <= c_grant && !c_clr;
            if (c_grant && !c_clr) c_rdata <= slots[c_addr];
        end
    end
endmodule

// File: rtl/txq_ctrl.sv
// Consumer sequencer. It polls the head slot, raises a held link request
// when the slot is owned, clears the slot's flag after the acknowledge and
// steps the head. Assumes ack arrives only while the request is high.
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = 20,
    parameter int IDX_W = 14,
    parameter int ENT_W = PTR_W + IDX_W + 1,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             c_req,
    output logic             c_clr,
    output logic [AW-1:0]    c_addr,
    input  logic             c_grant,
    input  logic [ENT_W-1:0] c_rdata,
    input  logic             c_rvalid,
    output logic             link_req,
    output logic [PTR_W-1:0] link_ptr,
    output logic [IDX_W-1:0] link_idx,
    input  logic             link_ack,
    output logic [AW-1:0]    head
);
    cons_state_t      state, state_nx;
    logic             owned;
    logic [PTR_W-1:0] ptr_q;
    logic [IDX_W-1:0] idx_q;

    // A fresh read shows an owned slot
    always_comb owned = c_rvalid && c_rdata[0];

    // Storage access request for this cycle
    always_comb begin
        c_addr = head;
        c_clr  = (state == ST_CLEAR);
        c_req  = (state == ST_CLEAR) || (state == ST_POLL && !owned);
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        case (state)
            ST_POLL:  if (owned)    state_nx = ST_LINK;
            ST_LINK:  if (link_ack) state_nx = ST_CLEAR;
            ST_CLEAR: if (c_grant)  state_nx = ST_POLL;
            default:                state_nx = ST_POLL;
        endcase
    end

    // State, head pointer and captured request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_POLL;
            head  <= '0;
            ptr_q <= '0;
            idx_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_CLEAR && c_grant) head <= head + AW'(1);
            if (state == ST_POLL && owned) begin
                idx_q <= c_rdata[IDX_W:1];
                ptr_q <= c_rdata[ENT_W-1:IDX_W+1];
            end
        end
    end

    // Request outputs come straight from held registers
    always_comb begin
        link_req = (state == ST_LINK);
        link_ptr = ptr_q;
        link_idx = idx_q;
    end
endmodule

// File: rtl/txq_consumer.sv
// Top of the transmit work-queue consumer: ring storage plus sequencer.
// Assumes DEPTH is a power of two and that the host only writes a slot
// when that slot is not owned by the consumer.
module txq_consumer #(
    parameter int DEPTH = 16,
    parameter int PTR_W = 20,
    parameter int IDX_W = 14,
    localparam int ENT_W = PTR_W + IDX_W + 1,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_en,
    input  logic [AW-1:0]    host_wr_addr,
    input  logic [ENT_W-1:0] host_wr_data,
    output logic             link_req,
    output logic [PTR_W-1:0] link_ptr,
    output logic [IDX_W-1:0] link_idx,
    input  logic             link_ack,
    output logic [AW-1:0]    head
);
    logic             c_req, c_clr, c_grant, c_rvalid;
    logic [AW-1:0]    c_addr;
    logic [ENT_W-1:0] c_rdata;

    txq_ring_mem #(.DEPTH(DEPTH), .ENT_W(ENT_W), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .h_we(host_wr_en), .h_addr(host_wr_addr), .h_data(host_wr_data),
        .c_req(c_req), .c_clr(c_clr), .c_addr(c_addr),
        .c_grant(c_grant), .c_rdata(c_rdata), .c_rvalid(c_rvalid)
    );

    txq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .IDX_W(IDX_W),
               .ENT_W(ENT_W), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .c_req(c_req), .c_clr(c_clr), .c_addr(c_addr),
        .c_grant(c_grant), .c_rdata(c_rdata), .c_rvalid(c_rvalid),
        .link_req(link_req), .link_ptr(link_ptr), .link_idx(link_idx),
        .link_ack(link_ack), .head(head)
    );
endmodule

// File: rtl/txq_consumer_chk.sv
// Protocol checker for the transmit work-queue consumer, bound to the top.
module txq_consumer_chk #(
    parameter int PTR_W = 20,
    parameter int IDX_W = 14,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr_en,
    input logic             link_req,
    input logic [PTR_W-1:0] link_ptr,
    input logic [IDX_W-1:0] link_idx,
    input logic             link_ack,
    input logic [AW-1:0]    head
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        link_req && !link_ack |=> link_req && $stable(link_ptr) && $stable(link_idx)); // R5
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        link_req && link_ack |=> !link_req); // R6
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(head) |-> head == $past(head) + AW'(1)); // R7
    AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en |=> $stable(head)); // R8
    AST_HEAD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        link_req |=> $stable(head)); // R6
endmodule

bind txq_consumer txq_consumer_chk #(.PTR_W(PTR_W), .IDX_W(IDX_W), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en),
    .link_req(link_req), .link_ptr(link_ptr), .link_idx(link_idx),
    .link_ack(link_ack), .head(head)
);

// File: tb/txq_consumer_tb.sv
`timescale 1ns/1ps
// Directed bench for the transmit work-queue consumer.
module txq_consumer_tb;
    localparam int DEPTH = 16;
    localparam int PTR_W = 20;
    localparam int IDX_W = 14;
    localparam int ENT_W = PTR_W + IDX_W + 1;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_wr_en = 1'b0;
    logic [AW-1:0]    host_wr_addr = '0;
    logic [ENT_W-1:0] host_wr_data = '0;
    logic             link_req;
    logic [PTR_W-1:0] link_ptr;
    logic [IDX_W-1:0] link_idx;
    logic             link_ack = 1'b0;
    logic [AW-1:0]    head;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [AW-1:0] exp_head = '0;

    always #2.5 clk = ~clk;

    txq_consumer #(.DEPTH(DEPTH), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .link_req(link_req), .link_ptr(link_ptr), .link_idx(link_idx),
        .link_ack(link_ack), .head(head)
    );

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [ENT_W-1:0] mk(input logic [PTR_W-1:0] p,
                                             input logic [IDX_W-1:0] i,
                                             input logic v);
        return {p, i, v};   // R1 layout
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [ENT_W-1:0] d);
        host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    // Wait up to n cycles for a request; returns 1 when seen
    task automatic wait_req(input int n, output bit seen);
        seen = 0;
        for (int k = 0; k < n; k++) begin
            if (link_req) begin seen = 1; return; end
            @(negedge clk);
        end
        seen = link_req;
    endtask

    // Acknowledge and check drop plus head step
    task automatic ack_and_step(input string req);
        link_ack = 1'b1;
        @(negedge clk);
        link_ack = 1'b0;
        check({req, " req drop"}, 64'(link_req), 64'd0);
        @(negedge clk);
        exp_head = exp_head + AW'(1);
        check({req, " head step"}, 64'(head), 64'(exp_head));
    endtask

    // Submit at the head slot and consume it
    task automatic consume_one(input string req, input logic [PTR_W-1:0] p, input logic [IDX_W-1:0] i);
        bit seen;
        host_write(exp_head, mk(p, i, 1'b1));
        wait_req(10, seen);
        check({req, " req seen"}, 64'(seen), 64'd1);
        check({req, " ptr"}, 64'(link_ptr), 64'(p));
        check({req, " idx"}, 64'(link_idx), 64'(i));
        ack_and_step(req);
    endtask

    task automatic t_reset();   // R2
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 req", 64'(link_req), 64'd0);
        check("R2 head", 64'(head), 64'd0);
        repeat (5) @(negedge clk);
        check("R2 no owned slot", 64'(link_req), 64'd0);
    endtask

    task automatic t_basic_hold();   // R3 R5 R6
        bit seen;
        host_write(exp_head, mk(20'hABCDE, 14'h1234, 1'b1));
        wait_req(10, seen);
        check("R3 req", 64'(seen), 64'd1);
        check("R3 ptr", 64'(link_ptr), 64'h ABCDE);
        check("R3 idx", 64'(link_idx), 64'h1234);
        repeat (6) @(negedge clk);
        check("R5 req held", 64'(link_req), 64'd1);
        check("R5 ptr held", 64'(link_ptr), 64'hABCDE);
        check("R5 idx held", 64'(link_idx), 64'h1234);
        check("R5 head held", 64'(head), 64'(exp_head));
        ack_and_step("R6");
    endtask

    task automatic t_stall_then_fill();   // R4 R1
        bit seen;
        host_write(exp_head, mk(20'h11111, 14'h0222, 1'b0));
        repeat (10) @(negedge clk);
        check("R4 no req on clear flag", 64'(link_req), 64'd0);
        check("R4 head holds", 64'(head), 64'(exp_head));
        host_write(exp_head + AW'(1), mk(20'h33333, 14'h0444, 1'b1));
        repeat (8) @(negedge clk);
        check("R4 next slot not skipped to", 64'(link_req), 64'd0);
        host_write(exp_head, mk(20'h55555, 14'h0666, 1'b1));
        wait_req(10, seen);
        check("R4 pickup", 64'(seen), 64'd1);
        check("R1 ptr field", 64'(link_ptr), 64'h55555);
        check("R1 idx field", 64'(link_idx), 64'h0666);
        ack_and_step("R4");
        wait_req(10, seen);
        check("R7 following slot", 64'(seen), 64'd1);
        check("R7 following ptr", 64'(link_ptr), 64'h33333);
        ack_and_step("R7");
    endtask

    task automatic t_order();   // R7
        bit seen;
        for (int k = 0; k < 3; k++)
            host_write(exp_head + AW'(k), mk(PTR_W'(20'h70000 + k), IDX_W'(14'h100 + k), 1'b1));
        for (int k = 0; k < 3; k++) begin
            wait_req(10, seen);
            check("R7 order req", 64'(seen), 64'd1);
            check("R7 order idx", 64'(link_idx), 64'(14'h100 + k));
            ack_and_step("R7");
        end
    endtask

    task automatic t_collide();   // R8
        bit seen;
        host_write(exp_head, mk(20'h0BEEF, 14'h0ACE, 1'b1));
        host_wr_en = 1'b1;
        host_wr_addr = exp_head + AW'(8);
        host_wr_data = '0;
        repeat (10) @(negedge clk);
        check("R8 read blocked", 64'(link_req), 64'd0);
        host_wr_en = 1'b0;
        wait_req(10, seen);
        check("R8 read retried", 64'(seen), 64'd1);
        check("R8 ptr", 64'(link_ptr), 64'h0BEEF);
        link_ack = 1'b1;
        @(negedge clk);
        link_ack = 1'b0;
        host_wr_en = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 clear blocked", 64'(head), 64'(exp_head));
        host_wr_en = 1'b0;
        @(negedge clk);
        exp_head = exp_head + AW'(1);
        check("R8 clear retried", 64'(head), 64'(exp_head));
    endtask

    task automatic t_wrap();   // R7 R9
        bit seen;
        for (int k = 0; k < DEPTH; k++)
            consume_one("R7 wrap", PTR_W'(20'h80000 + k), IDX_W'(k * 3));
        repeat (10) @(negedge clk);
        check("R9 no relink", 64'(link_req), 64'd0);
        check("R9 head held", 64'(head), 64'(exp_head));
        host_write(exp_head, mk(20'hFEDCB, 14'h3FFF, 1'b1));
        wait_req(10, seen);
        check("R9 resubmit", 64'(seen), 64'd1);
        check("R9 idx", 64'(link_idx), 64'h3FFF);
        ack_and_step("R9");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic_hold();
        t_stall_then_fill();
        t_order();
        t_collide();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule